// File: doc/BRIEF.md
# I2C Target Address Matcher

This block sits on the bus side of an I2C target. It brings SCL and SDA into the system clock domain through a short synchronizer chain and finds the bus conditions on the synchronized lines. A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. After every START or repeated START it collects the first byte and decides whether this target is being addressed. The target can be built for a 7-bit address or for a 10-bit address. In both cases the lowest address bits come from configuration pins, so several identical targets can share one bus.

On a match the block pulls SDA low for the acknowledge slot. After acknowledging its own address it may hold SCL low until local logic says it is ready. It reports a matched flag, the transfer direction and a general-call flag to local logic. The command byte that follows a general call is also handed over. Reserved addresses, including the start byte, are never acknowledged. The block contains only open-drain enables: a 1 on either drive output means "pull the line low". The system clock must run at least four times faster than SCL.

Top module: `i2c_addr_match`

## Requirements
- R1: `busy_o` goes high one cycle after a START is detected, meaning an SDA fall while SCL is high on the synchronized lines. It goes low after a STOP, meaning an SDA rise while SCL is high.
- R2: In 7-bit mode the first byte after START is taken MSB first as seven address bits followed by a direction bit (0 = controller writes, 1 = controller reads). When the seven bits equal the target address, the target acknowledges, sets `match_o` and copies the direction bit to `read_o`.
- R3: The target address takes its low `PIN_W` bits from `cfg_pins_i` and its remaining bits from `BASE_ADDR`.
- R4: In 10-bit mode, a first byte `11110 A9 A8 0` is acknowledged when A9..A8 equal address bits 9..8. The next byte is acknowledged and sets `match_o` with `read_o` = 0 only if it equals address bits 7..0. A mismatching low byte is not acknowledged.
- R5: In 10-bit mode, a first byte `11110 A9 A8 1` is acknowledged, with `match_o` and `read_o` set, only if a full 10-bit write match has completed since the last STOP. Otherwise it is left unacknowledged.
- R6: The all-zero byte 0x00 (general call) is acknowledged in both modes and sets `gcall_o`. The following byte is acknowledged and appears on `gcall_cmd_o`, with `gcall_cmd_vld_o` high for exactly one cycle.
- R7: The start byte 0x01 is never acknowledged. Other addresses of the form 0000xxx, the form 11111xx, and in 7-bit mode the form 11110xx are never acknowledged.
- R8: A byte that does not match leaves SDA released, leaves `match_o`, `read_o` and `gcall_o` low, and makes the target ignore the bus until the next START or STOP.
- R9: The target drives SDA only in the acknowledge slot. The drive starts and ends while synchronized SCL is low, and during the eight address bits SDA carries exactly the controller's bits.
- R10: After acknowledging the byte that sets `match_o`, the target holds `scl_drive_o` from the next SCL fall while `local_ready_i` is low. It releases SCL one cycle after `local_ready_i` is high, and never drives SDA and SCL together.
- R11: A START or repeated START clears `match_o`, `read_o` and `gcall_o` on the following cycle, and a STOP clears them too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| cfg_pins_i | input | PIN_W | Pin-strapped low address bits |
| local_ready_i | input | 1 | Local logic ready; releases a held SCL |
| sda_drive_o | output | 1 | 1 pulls SDA low (acknowledge) |
| scl_drive_o | output | 1 | 1 pulls SCL low (clock stretch) |
| busy_o | output | 1 | Bus between START and STOP |
| match_o | output | 1 | Own address matched in this transfer |
| read_o | output | 1 | Direction of the matched transfer, 1 = read |
| gcall_o | output | 1 | General call received in this transfer |
| gcall_cmd_o | output | 8 | Command byte following a general call |
| gcall_cmd_vld_o | output | 1 | One-cycle strobe for `gcall_cmd_o` |

## Verification
The bench places two instances on one shared open-drain bus model. The first is a 7-bit target with base 0x050 and two pin bits. The second is a 10-bit target with base 0x2A5 and two pin bits strapped to 2'b10, which gives address 0x2A6. With both on the same wires, every byte shows at once whether one target, both targets or neither acknowledges. This covers a 10-bit prefix that the 7-bit target must reject and a general call that both must accept. Changing the 7-bit pins between transfers moves that target's address, and holding one ready input low exercises the stretch on the shared SCL.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [1:0] {K_FIRST, K_LOW10, K_GCMD} kind_e;
  typedef enum logic [2:0] {ST_IDLE, ST_RECV, ST_ACK, ST_HOLD, ST_PARK} state_e;

  typedef struct packed {
    logic  ack;   // pull SDA in the acknowledge slot
    logic  fin;   // own address fully matched
    logic  gc;    // general call address
    logic  rd;    // direction of a final match
    logic  cmd;   // byte is a general-call command
    logic  more;  // another address-phase byte follows
    kind_e nxt;   // kind of that next byte
  } verdict_t;

  // 7-bit codes the target must never claim as its own
  function automatic logic reserved7(input logic [6:0] a);
    return (a[6:3] == 4'b0000) || (a[6:3] == 4'b1111);
  endfunction

  function automatic verdict_t judge(input kind_e k, input logic [7:0] b,
                                     input logic ten, input logic [9:0] own,
                                     input logic ten_ok);
    verdict_t v;
    v = '0;
    v.nxt = K_FIRST;
    case (k)
      K_FIRST: begin
        if (b == 8'h00) begin
          v.ack = 1'b1; v.gc = 1'b1; v.more = 1'b1; v.nxt = K_GCMD;
        end else if (ten && b[7:3] == 5'b11110 && b[2:1] == own[9:8]) begin
          if (!b[0]) begin
            v.ack = 1'b1; v.more = 1'b1; v.nxt = K_LOW10;
          end else if (ten_ok) begin
            v.ack = 1'b1; v.fin = 1'b1; v.rd = 1'b1;
          end
        end else if (!ten && b[7:1] == own[6:0] && !reserved7(b[7:1])) begin
          v.ack = 1'b1; v.fin = 1'b1; v.rd = b[0];
        end
      end
      K_LOW10: begin
        if (b == own[7:0]) begin
          v.ack = 1'b1; v.fin = 1'b1;
        end
      end
      K_GCMD: begin
        v.ack = 1'b1; v.cmd = 1'b1;
      end
      default: ;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  // chain[k] = {scl, sda} after k+1 flops; idle bus reads high
  logic [SYNC_STAGES-1:0][1:0] chain;
  logic [1:0] prev;
  logic [1:0] now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 2'b11;
    end else begin
      chain <= {chain[SYNC_STAGES-2:0], {scl_i, sda_i}};
      prev  <= chain[SYNC_STAGES-1];
    end
  end

  assign now     = chain[SYNC_STAGES-1];
  assign scl_s   = now[1];
  assign sda_s   = now[0];
  assign start_o = now[1] & prev[1] & prev[0] & ~now[0];
  assign stop_o  = now[1] & prev[1] & ~prev[0] & now[0];
  assign rise_o  = now[1] & ~prev[1];
  assign fall_o  = ~now[1] & prev[1];
endmodule

// File: rtl/i2c_addr_compose.sv
module i2c_addr_compose #(
  parameter logic [9:0] BASE_ADDR = 10'h050,
  parameter int         PIN_W     = 2
) (
  input  logic [PIN_W-1:0] pins_i,
  output logic [9:0]       addr_o
);
  for (genvar i = 0; i < 10; i++) begin : g_bit
    if (i < PIN_W) begin : g_pin
      assign addr_o[i] = pins_i[i];
    end else begin : g_fix
      assign addr_o[i] = BASE_ADDR[i];
    end
  end
endmodule

// File: rtl/i2c_addr_fsm.sv
module i2c_addr_fsm
  import i2c_tgt_pkg::*;
#(
  parameter bit TEN_BIT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic [9:0] own_addr,
  input  logic       local_ready_i,
  output logic       sda_drive_o,
  output logic       scl_drive_o,
  output logic       busy_o,
  output logic       match_o,
  output logic       read_o,
  output logic       gcall_o,
  output logic [7:0] gcall_cmd_o,
  output logic       gcall_cmd_vld_o
);
  localparam logic [3:0] BYTE_BITS = 4'd8;

  state_e     st;
  kind_e      kind;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic       ten_ok;
  logic       fin_q;
  logic       more_q;
  verdict_t   v;
  logic       byte_done;

  assign v         = judge(kind, shreg, TEN_BIT, own_addr, ten_ok);
  assign byte_done = (st == ST_RECV) && (cnt == BYTE_BITS) && scl_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; kind <= K_FIRST; cnt <= '0; shreg <= '0;
      ten_ok <= 1'b0; fin_q <= 1'b0; more_q <= 1'b0;
      sda_drive_o <= 1'b0; scl_drive_o <= 1'b0; busy_o <= 1'b0;
      match_o <= 1'b0; read_o <= 1'b0; gcall_o <= 1'b0;
      gcall_cmd_o <= '0; gcall_cmd_vld_o <= 1'b0;
    end else begin
      gcall_cmd_vld_o <= 1'b0;
      if (stop_evt) begin
        st <= ST_IDLE; busy_o <= 1'b0; ten_ok <= 1'b0;
        match_o <= 1'b0; read_o <= 1'b0; gcall_o <= 1'b0;
        sda_drive_o <= 1'b0; scl_drive_o <= 1'b0;
      end else if (start_evt) begin
        st <= ST_RECV; kind <= K_FIRST; cnt <= '0; busy_o <= 1'b1;
        match_o <= 1'b0; read_o <= 1'b0; gcall_o <= 1'b0;
        sda_drive_o <= 1'b0; scl_drive_o <= 1'b0;
      end else begin
        case (st)
          ST_RECV: begin
            if (scl_rise && cnt < BYTE_BITS) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (byte_done) begin
              if (v.ack) begin
                st <= ST_ACK; sda_drive_o <= 1'b1;
                fin_q <= v.fin; more_q <= v.more; kind <= v.nxt;
                if (v.fin) begin match_o <= 1'b1; read_o <= v.rd; end
                if (v.gc) gcall_o <= 1'b1;
                if (v.cmd) begin gcall_cmd_o <= shreg; gcall_cmd_vld_o <= 1'b1; end
                if (kind == K_LOW10) ten_ok <= 1'b1;
              end else begin
                st <= ST_PARK;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_drive_o <= 1'b0;
              cnt <= '0;
              if (fin_q && !local_ready_i) begin
                st <= ST_HOLD; scl_drive_o <= 1'b1;
              end else if (more_q) begin
                st <= ST_RECV;
              end else begin
                st <= ST_PARK;
              end
            end
          end
          ST_HOLD: begin
            if (local_ready_i) begin
              scl_drive_o <= 1'b0; st <= ST_PARK;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // ---------------- assertions ----------------
  p_busy_on_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy_o);
  p_busy_off_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !busy_o);
  p_start_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!match_o && !read_o && !gcall_o));
  p_ack_rise_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_o) |-> !scl_s);
  p_ack_fall_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_drive_o) |-> !scl_s);
  p_hold_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_drive_o && local_ready_i) |=> !scl_drive_o);
  p_hold_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_drive_o && !local_ready_i && !stop_evt && !start_evt) |=> scl_drive_o);
  p_no_dual_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sda_drive_o && scl_drive_o));
  p_cmd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gcall_cmd_vld_o |=> !gcall_cmd_vld_o);
  p_ten_read_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (TEN_BIT && $rose(match_o) && read_o) |-> ten_ok);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_tgt_pkg::*;
#(
  parameter bit         TEN_BIT     = 1'b0,
  parameter logic [9:0] BASE_ADDR   = 10'h050,
  parameter int         PIN_W       = 2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [PIN_W-1:0] cfg_pins_i,
  input  logic             local_ready_i,
  output logic             sda_drive_o,
  output logic             scl_drive_o,
  output logic             busy_o,
  output logic             match_o,
  output logic             read_o,
  output logic             gcall_o,
  output logic [7:0]       gcall_cmd_o,
  output logic             gcall_cmd_vld_o
);
  // named internal events, visible to the assertions
  logic       scl_s, sda_s, start_evt, stop_evt, scl_rise, scl_fall;
  logic [9:0] own_addr;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .start_o(start_evt), .stop_o(stop_evt),
    .rise_o(scl_rise), .fall_o(scl_fall)
  );

  i2c_addr_compose #(.BASE_ADDR(BASE_ADDR), .PIN_W(PIN_W)) u_addr (
    .pins_i(cfg_pins_i), .addr_o(own_addr)
  );

  i2c_addr_fsm #(.TEN_BIT(TEN_BIT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .own_addr(own_addr),
    .local_ready_i(local_ready_i),
    .sda_drive_o(sda_drive_o), .scl_drive_o(scl_drive_o), .busy_o(busy_o),
    .match_o(match_o), .read_o(read_o), .gcall_o(gcall_o),
    .gcall_cmd_o(gcall_cmd_o), .gcall_cmd_vld_o(gcall_cmd_vld_o)
  );

  p_match_not_gcall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(match_o && gcall_o));
  p_stop_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!match_o && !scl_drive_o && !sda_drive_o));
endmodule

// File: tb/test_i2c_addr_match.sv
module test_i2c_addr_match;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_c = 1'b1, sda_c = 1'b1;
  logic [1:0] pins7 = 2'b11, pins10 = 2'b10;
  logic rdy7 = 1'b1, rdy10 = 1'b1;
  logic sdrv7, cdrv7, busy7, m7, r7, g7, v7;
  logic sdrv10, cdrv10, busy10, m10, r10, g10, v10;
  logic [7:0] cmd7, cmd10;
  logic scl_line, sda_line;

  assign scl_line = scl_c & ~cdrv7 & ~cdrv10;
  assign sda_line = sda_c & ~sdrv7 & ~sdrv10;

  i2c_addr_match #(.TEN_BIT(1'b0), .BASE_ADDR(10'h050), .PIN_W(2)) i_i2c_addr_match (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .cfg_pins_i(pins7), .local_ready_i(rdy7),
    .sda_drive_o(sdrv7), .scl_drive_o(cdrv7), .busy_o(busy7), .match_o(m7),
    .read_o(r7), .gcall_o(g7), .gcall_cmd_o(cmd7), .gcall_cmd_vld_o(v7));

  i2c_addr_match #(.TEN_BIT(1'b1), .BASE_ADDR(10'h2A5), .PIN_W(2)) i_i2c_addr_match_ten (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .cfg_pins_i(pins10), .local_ready_i(rdy10),
    .sda_drive_o(sdrv10), .scl_drive_o(cdrv10), .busy_o(busy10), .match_o(m10),
    .read_o(r10), .gcall_o(g10), .gcall_cmd_o(cmd10), .gcall_cmd_vld_o(v10));

  localparam int Q = 16;
  int n_chk = 0, n_err = 0;
  int nv7 = 0, nv10 = 0;
  logic [7:0] got7 = '0, got10 = '0;

  typedef struct { logic [6:0] v; string tag; } item_t;
  item_t q[$];
  event ack_ev;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (scl_line !== 1'b1) @(negedge clk);
  endtask

  // command strobe capture
  always @(negedge clk) begin
    if (v7)  begin nv7++;  got7  = cmd7;  end
    if (v10) begin nv10++; got10 = cmd10; end
  end

  // monitor: compares the acknowledge slot with the queued expectation
  initial forever begin
    item_t it;
    @(ack_ev);
    if (q.size() == 0) begin
      n_chk++; n_err++;
      $display("FAIL monitor actual=empty expected=item");
    end else begin
      it = q.pop_front();
      chk(it.tag, {25'd0, ~sda_line, m7, r7, g7, m10, r10, g10}, {25'd0, it.v});
    end
  end

  task automatic do_start();
    sda_c = 1'b1; hw(Q); scl_c = 1'b1; wait_scl_high(); hw(Q);
    sda_c = 1'b0; hw(Q); scl_c = 1'b0; hw(Q);
  endtask

  task automatic do_stop();
    sda_c = 1'b0; hw(Q); scl_c = 1'b1; wait_scl_high(); hw(Q);
    sda_c = 1'b1; hw(Q);
  endtask

  // exp = {ack, m7, r7, g7, m10, r10, g10}
  task automatic send_byte(input logic [7:0] b, input logic [6:0] exp, input string tag);
    for (int i = 7; i >= 0; i--) begin
      sda_c = b[i]; hw(Q); scl_c = 1'b1; wait_scl_high(); hw(Q/2);
      chk("R9 data bit", sda_line, b[i]);
      hw(Q/2); scl_c = 1'b0; hw(Q);
    end
    sda_c = 1'b1; hw(Q);
    q.push_back('{exp, tag});
    scl_c = 1'b1; wait_scl_high(); hw(Q/2);
    -> ack_ev;
    hw(Q/2); scl_c = 1'b0; hw(Q);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    hw(5); rst_n = 1'b1; hw(5);
    chk("R1 reset", {busy7, m7, g7, sdrv7, cdrv7, busy10, m10, g10, sdrv10, cdrv10}, 0);

    // R1 / R2: 7-bit write match (own 0x53 -> byte A6)
    do_start();
    chk("R1 busy after START", {busy7, busy10}, 2'b11);
    send_byte(8'hA6, 7'b1_100_000, "R2 write match");
    do_stop();
    chk("R1 idle after STOP", {busy7, busy10}, 2'b00);
    chk("R11 STOP clears", m7, 0);

    // R2 read, R11 repeated START, R8 mismatch
    do_start();
    send_byte(8'hA7, 7'b1_110_000, "R2 read match");
    do_start();
    chk("R11 repeated START clears", {m7, r7}, 2'b00);
    send_byte(8'hA4, 7'b0_000_000, "R8 mismatch nack");
    do_stop();

    // R3 pin-strapped bits move the address to 0x52
    pins7 = 2'b10; hw(Q);
    do_start();
    send_byte(8'hA4, 7'b1_100_000, "R3 pins select address");
    do_stop();
    pins7 = 2'b11; hw(Q);

    // R4 10-bit write, R5 read after repeated START
    do_start();
    send_byte(8'hF4, 7'b1_000_000, "R4 prefix write");
    send_byte(8'hA6, 7'b1_000_100, "R4 low byte match");
    do_start();
    send_byte(8'hF5, 7'b1_000_110, "R5 read after write");
    do_stop();

    // R5 read without earlier write since STOP
    do_start();
    send_byte(8'hF5, 7'b0_000_000, "R5 read without write");
    do_stop();

    // R4 wrong low byte, then R5 read must fail
    do_start();
    send_byte(8'hF4, 7'b1_000_000, "R4 prefix write");
    send_byte(8'hA7, 7'b0_000_000, "R4 low byte mismatch");
    do_start();
    send_byte(8'hF5, 7'b0_000_000, "R5 read after failed write");
    do_stop();

    // R6 general call plus command byte
    do_start();
    send_byte(8'h00, 7'b1_001_001, "R6 general call");
    send_byte(8'h06, 7'b1_001_001, "R6 command ack");
    chk("R6 command strobes", {nv7[7:0], nv10[7:0]}, 16'h0101);
    chk("R6 command value", {got7, got10}, 16'h0606);
    do_stop();

    // R7 start byte and reserved codes
    do_start(); send_byte(8'h01, 7'b0_000_000, "R7 start byte"); do_stop();
    do_start(); send_byte(8'h0A, 7'b0_000_000, "R7 reserved 0000xxx"); do_stop();
    do_start(); send_byte(8'hF8, 7'b0_000_000, "R7 reserved 11111xx"); do_stop();

    // R10 clock stretch on the 7-bit target
    rdy7 = 1'b0;
    do_start();
    send_byte(8'hA6, 7'b1_100_000, "R10 match before stretch");
    sda_c = 1'b0; hw(Q); scl_c = 1'b1; hw(100);
    chk("R10 SCL held low", scl_line, 0);
    chk("R10 SDA released during hold", sdrv7, 0);
    rdy7 = 1'b1; hw(2);
    chk("R10 SCL released", scl_line, 1);
    hw(Q); sda_c = 1'b1; hw(Q);
    chk("R1 idle after stretch STOP", busy7, 0);

    hw(20);
    if (q.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL monitor actual=%0d left expected=0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule